// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block is the presentation stage that sits between an interrupt source layer and one processor. It keeps three pieces of state: the processor's current priority, a single pending interrupt (source number plus its priority), and a priority register for the inter-processor interrupt (IPI). Priority values are 8 bits. A numerically lower value is more favoured, and 0xFF is the least favoured value.

The source layer offers interrupts one at a time. Each offer is either taken into the pending slot or handed straight back as a reject. A taken offer can displace a less favoured pending interrupt, and the displaced one is rejected. The processor side uses four single-cycle commands: set current priority, set IPI priority, accept, and end-of-interrupt. Toward the source layer the block sends one-cycle pulses for reject, resend request and EOI. A reject or EOI pulse carries a source number. The level output `irq_o` tells the processor that something is pending.

The 32-bit presented word has the current priority in bits 31:24 and the pending source number in bits 23:0. A source number of zero means nothing is pending. The IPI uses a fixed source number, set by the parameter `IPI_SRC` (default 2).

Top module: `irq_presenter`

## Requirements
- R1: After reset, `irq_o` is low, the presented word is 0, the pending priority is 0xFF and the IPI priority is 0xFF. So a first accept returns 0, and a second accept returns 0xFF000000.
- R2: An offer whose priority is greater than or equal to the current priority is rejected on `rej_src`. The pending slot is left unchanged.
- R3: An offer is also rejected, with the slot unchanged, when an interrupt is already pending at an equal or more favoured priority.
- R4: An offer that is not refused is stored with its priority and raises `irq_o`. If another interrupt was pending, that displaced source number is rejected in the same cycle.
- R5: Writing the IPI priority always stores it. If the new value is below the current priority, the IPI check runs. The check does nothing when a pending interrupt has a priority less than or equal to the IPI value. Otherwise it rejects any pending source, loads `IPI_SRC` with the IPI priority, and raises `irq_o`.
- R6: Writing a current priority below the old one clears the pending interrupt, but only when one exists and the new value is less than or equal to its priority. When that happens, the pending priority becomes 0xFF, `irq_o` drops and the cleared source is rejected.
- R7: Writing a current priority greater than or equal to the old one, with nothing pending, sends a resend request. Before the request, the IPI check runs if the IPI priority is below the new current priority.
- R8: Accept returns the whole presented word on `acc_data` and lowers `irq_o`. It then loads the pending priority into the current priority, clears the source number and sets the pending priority to 0xFF.
- R9: EOI takes a 32-bit value. Bits 31:24 become the current priority and bits 23:0 are sent on `eoi_src`. If nothing is pending, a resend follows, with the IPI check as in R7.
- R10: Each pulse output lasts exactly one cycle per cause, and `irq_o` is high exactly when a nonzero source number is pending. Offers and commands never arrive in the same cycle. The command codes are 0 idle, 1 set current, 2 set IPI, 3 accept and 4 EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_vld | input | 1 | Source layer offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number (nonzero) |
| offer_prio | input | 8 | Offered priority |
| cmd_op | input | 3 | Command code (0 idle, 1 set current, 2 set IPI, 3 accept, 4 EOI) |
| cmd_data | input | 32 | Command operand (priority in bits 7:0, or the EOI word) |
| irq_o | output | 1 | Interrupt level to the processor |
| acc_vld | output | 1 | Accept result valid (one cycle) |
| acc_data | output | 32 | Presented word returned by accept |
| rej_vld | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request pulse to the source layer |
| eoi_vld | output | 1 | EOI pulse to the source layer |
| eoi_src | output | 24 | Source number being ended |

## Verification
A wrong current or pending priority first shows up in the reject decision. It appears on `rej_vld` or `rej_src` in the cycle right after the next offer or command. A wrong value stored in the slot becomes visible at the next accept: the first accept returns the priority and number, and a second accept brings the pending priority out through the current-priority byte. A lost or stale pending state breaks the link between `irq_o` and the slot within one cycle. The sweep therefore walks every combination of current priority, pending priority and offered priority over a small range, and reads the state back through two accepts after each case.

// File: rtl/irq_presenter.sv
module irq_presenter #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_vld,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  input  logic [2:0]              cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  output logic                    irq_o,
  output logic                    acc_vld,
  output logic [PRIO_W+SRC_W-1:0] acc_data,
  output logic                    rej_vld,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    resend_req,
  output logic                    eoi_vld,
  output logic [SRC_W-1:0]        eoi_src
);
  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  NONE  = '0;
  localparam logic [2:0] OP_CUR = 3'd1, OP_IPI = 3'd2, OP_ACC = 3'd3, OP_EOI = 3'd4;

  logic [PRIO_W-1:0] cur_q, pend_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              irq_q;

  logic [PRIO_W-1:0] cur_d, pend_d, ipi_d, wr_prio, eoi_prio;
  logic [SRC_W-1:0]  src_d, rej_s, eoi_s;
  logic              irq_d, rej, rsnd, eoi, acc, run_ipi;
  logic [REG_W-1:0]  acc_d;

  assign wr_prio  = cmd_data[PRIO_W-1:0];
  assign eoi_prio = cmd_data[REG_W-1:SRC_W];

  always_comb begin
    cur_d = cur_q; pend_d = pend_q; ipi_d = ipi_q; src_d = src_q; irq_d = irq_q;
    rej = 1'b0; rej_s = NONE; rsnd = 1'b0; eoi = 1'b0; eoi_s = NONE;
    acc = 1'b0; acc_d = '0; run_ipi = 1'b0;
    case (cmd_op)
      OP_CUR: begin
        cur_d = wr_prio;
        if (wr_prio < cur_q) begin
          if (src_q != NONE && wr_prio <= pend_q) begin
            rej = 1'b1; rej_s = src_q;
            src_d = NONE; pend_d = LEAST; irq_d = 1'b0;
          end
        end else if (src_q == NONE) begin
          rsnd = 1'b1;
          run_ipi = ipi_q < wr_prio;
        end
      end
      OP_IPI: begin
        ipi_d = wr_prio;
        run_ipi = wr_prio < cur_q;
      end
      OP_ACC: begin
        acc = 1'b1; acc_d = {cur_q, src_q};
        cur_d = pend_q; src_d = NONE; pend_d = LEAST; irq_d = 1'b0;
      end
      OP_EOI: begin
        cur_d = eoi_prio;
        eoi = 1'b1; eoi_s = cmd_data[SRC_W-1:0];
        if (src_q == NONE) begin
          rsnd = 1'b1;
          run_ipi = ipi_q < eoi_prio;
        end
      end
      default: begin
        if (offer_vld) begin
          if (offer_prio >= cur_q || (src_q != NONE && pend_q <= offer_prio)) begin
            rej = 1'b1; rej_s = offer_src;
          end else begin
            if (src_q != NONE) begin
              rej = 1'b1; rej_s = src_q;
            end
            src_d = offer_src; pend_d = offer_prio; irq_d = 1'b1;
          end
        end
      end
    endcase
    if (run_ipi && !(src_d != NONE && pend_d <= ipi_d)) begin
      if (src_d != NONE) begin
        rej = 1'b1; rej_s = src_d;
      end
      src_d = SRC_W'(IPI_SRC); pend_d = ipi_d; irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0; src_q <= NONE; pend_q <= LEAST; ipi_q <= LEAST; irq_q <= 1'b0;
      acc_vld <= 1'b0; acc_data <= '0; rej_vld <= 1'b0; rej_src <= NONE;
      resend_req <= 1'b0; eoi_vld <= 1'b0; eoi_src <= NONE;
    end else begin
      cur_q <= cur_d; src_q <= src_d; pend_q <= pend_d; ipi_q <= ipi_d; irq_q <= irq_d;
      acc_vld <= acc; acc_data <= acc_d; rej_vld <= rej; rej_src <= rej_s;
      resend_req <= rsnd; eoi_vld <= eoi; eoi_src <= eoi_s;
    end
  end

  assign irq_o = irq_q;

  assert_level_matches_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (src_q != NONE));

  assert_empty_slot_least_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == NONE) |-> (pend_q == LEAST));

  assert_exclusive_inputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({offer_vld, cmd_op != 3'd0}) <= 1);

  assert_refuse_unfavoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_vld && cmd_op == 3'd0 && offer_prio >= cur_q)
      |=> (rej_vld && rej_src == $past(offer_src) && $stable(src_q)));

  assert_accept_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_ACC) |=> (acc_vld && !irq_o && src_q == NONE));

  assert_eoi_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_EOI) |=> (eoi_vld && eoi_src == $past(cmd_data[SRC_W-1:0])));
endmodule

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic offer_vld = 1'b0;
  logic [23:0] offer_src = '0;
  logic [7:0] offer_prio = '0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic irq_o, acc_vld, rej_vld, resend_req, eoi_vld;
  logic [31:0] acc_data;
  logic [23:0] rej_src, eoi_src;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic s_irq, s_acc, s_rej, s_rsnd, s_eoi;
  logic [31:0] s_accd;
  logic [23:0] s_rejsrc, s_eoisrc;

  always #4 clk = ~clk;

  irq_presenter dut_i (
    .clk(clk), .rst_n(rst_n), .offer_vld(offer_vld), .offer_src(offer_src),
    .offer_prio(offer_prio), .cmd_op(cmd_op), .cmd_data(cmd_data), .irq_o(irq_o),
    .acc_vld(acc_vld), .acc_data(acc_data), .rej_vld(rej_vld), .rej_src(rej_src),
    .resend_req(resend_req), .eoi_vld(eoi_vld), .eoi_src(eoi_src));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [31:0] d,
                      input logic ov, input logic [23:0] os, input logic [7:0] opr);
    @(negedge clk);
    cmd_op = op; cmd_data = d; offer_vld = ov; offer_src = os; offer_prio = opr;
    @(posedge clk); #1;
    s_irq = irq_o; s_acc = acc_vld; s_accd = acc_data; s_rej = rej_vld;
    s_rejsrc = rej_src; s_rsnd = resend_req; s_eoi = eoi_vld; s_eoisrc = eoi_src;
    cmd_op = 3'd0; offer_vld = 1'b0;
  endtask

  task automatic cur(input logic [7:0] p); step(3'd1, {24'd0, p}, 1'b0, 24'd0, 8'd0); endtask
  task automatic ipi(input logic [7:0] p); step(3'd2, {24'd0, p}, 1'b0, 24'd0, 8'd0); endtask
  task automatic acc(); step(3'd3, 32'd0, 1'b0, 24'd0, 8'd0); endtask
  task automatic eoi(input logic [31:0] w); step(3'd4, w, 1'b0, 24'd0, 8'd0); endtask
  task automatic offer(input logic [23:0] s, input logic [7:0] p); step(3'd0, 32'd0, 1'b1, s, p); endtask
  task automatic idle(); step(3'd0, 32'd0, 1'b0, 24'd0, 8'd0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    acc();  chk("R1 word after reset", s_accd, 32'h0000_0000);
    chk("R8 accept valid", {31'd0, s_acc}, 32'd1);
    acc();  chk("R1 pending prio after reset", s_accd, 32'hFF00_0000);
    cur(8'hFF);
    chk("R7 resend on equal", {31'd0, s_rsnd}, 32'd1);
    chk("R1 ipi prio least", {31'd0, s_irq}, 32'd0);

    ipi(8'd5);
    chk("R5 ipi loads", {31'd0, s_irq}, 32'd1);
    chk("R5 no reject when empty", {31'd0, s_rej}, 32'd0);
    offer(24'd50, 8'd3);
    chk("R4 displaced ipi", {8'd0, s_rejsrc}, 32'd2);
    idle();
    chk("R10 reject pulse one cycle", {31'd0, s_rej}, 32'd0);
    ipi(8'd4);
    chk("R5 check blocked by pending", {31'd0, s_rej}, 32'd0);
    ipi(8'd1);
    chk("R5 ipi displaces", {7'd0, s_rej, s_rejsrc}, {8'd1, 24'd50});
    acc();
    chk("R5 ipi presented", s_accd, 32'hFF00_0002);
    chk("R8 accept lowers irq", {31'd0, s_irq}, 32'd0);

    cur(8'd6);
    chk("R7 resend with ipi", {30'd0, s_rsnd, s_irq}, 32'd3);
    cur(8'd0);
    chk("R6 clear rejects", {7'd0, s_rej, s_rejsrc}, {8'd1, 24'd2});
    chk("R6 irq drops", {31'd0, s_irq}, 32'd0);
    ipi(8'hFF);
    cur(8'd7);
    chk("R7 resend no ipi", {30'd0, s_rsnd, s_irq}, 32'd2);
    offer(24'd9, 8'd4);
    cur(8'd5);
    chk("R6 not cleared above pending", {30'd0, s_rej, s_irq}, 32'd1);
    cur(8'd4);
    chk("R6 cleared at pending", {7'd0, s_rej, s_rejsrc}, {8'd1, 24'd9});

    eoi(32'h0300_0011);
    chk("R9 eoi source", {7'd0, s_eoi, s_eoisrc}, {8'd1, 24'h11});
    chk("R9 resend when empty", {31'd0, s_rsnd}, 32'd1);
    acc();
    chk("R9 eoi sets priority", s_accd, 32'h0300_0000);
    offer(24'd7, 8'd2);
    eoi(32'h0500_0007);
    chk("R9 no resend when pending", {31'd0, s_rsnd}, 32'd0);
    acc();
    chk("R9 priority from eoi", s_accd, 32'h0500_0007);
    acc();
    chk("R8 pending prio to current", s_accd, 32'h0200_0000);
    acc();

    for (int c = 1; c <= 6; c++) begin
      for (int pp = -1; pp < c; pp++) begin
        for (int op = 0; op <= 7; op++) begin
          bit refd, erej;
          logic [23:0] esrc, ersrc;
          logic [7:0] epp;
          string tag;
          cur(8'(c));
          if (pp >= 0) offer(24'd100, 8'(pp));
          offer(24'd200, 8'(op));
          refd = (op >= c) || (pp >= 0 && pp <= op);
          erej = refd ? 1'b1 : (pp >= 0);
          ersrc = refd ? 24'd200 : 24'd100;
          esrc = refd ? ((pp >= 0) ? 24'd100 : 24'd0) : 24'd200;
          epp = refd ? ((pp >= 0) ? 8'(pp) : 8'hFF) : 8'(op);
          tag = (op >= c) ? "R2 sweep" : (refd ? "R3 sweep" : "R4 sweep");
          chk(tag, {31'd0, s_rej}, {31'd0, erej});
          if (erej) chk(tag, {8'd0, s_rejsrc}, {8'd0, ersrc});
          chk("R10 sweep level", {31'd0, s_irq}, {31'd0, esrc != 24'd0});
          acc();
          chk(tag, s_accd, {8'(c), esrc});
          acc();
          chk("R8 sweep pending prio", s_accd, {epp, 24'd0});
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule